// File: doc/BRIEF.md
# Multi-Channel Interrupt Concentrator

This block gathers a wide bundle of level-sensitive, active-high peripheral interrupt lines onto a small number of processor interrupt inputs. Every source line reaches every channel. Each channel filters the shared sources through its own enable mask, exposes the masked result as a pending-status word, and drives one registered interrupt output that is high whenever any of its pending bits is set.

Software configures the block through a simple word register port made of an address, a write strobe, write data and read data. Channels are laid out at a fixed 64-byte stride. Within its slot, each channel has a read/write enable word at byte offset 0x10 and a read-only pending word at byte offset 0x20. An interrupt service routine reads the pending word of its channel to find which enabled sources are active. Pending bits follow the live source levels, so a source is cleared at the peripheral, not in this block.

Top module: `irq_concentrator`

## Requirements
- R1: Output `irq_out[c]` is high one clock edge after an edge at which at least one source enabled on channel c is high. It is low one edge after an edge at which no such source is high.
- R2: Every source line reaches every channel. One source can assert several channels at once, and each channel responds only according to its own mask.
- R3: The enable word of channel c is at byte address 0x40·c + 0x10. It is read/write and returns the last value written, limited to the low NUM_SRC bits. Upper bits read as zero.
- R4: The pending word of channel c is at byte address 0x40·c + 0x20. It reads as the live source levels ANDed with that channel's enable mask, with no latching: a source that drops reads as zero again.
- R5: Bit k of a channel's enable word gates source k on that channel only. Clearing the bit masks that source there without changing any other channel.
- R6: Writing zero to a channel's enable word disables all of its sources at once. Its output is low from the second edge after the write edge onward.
- R7: After reset, all enable words are zero, all outputs are low and the read data is zero.
- R8: The pending words ignore writes. No enable word changes and no output changes because of such a write.
- R9: A read of any byte address that is not an enable or pending word of an existing channel returns zero. This includes unaligned offsets and slots at or beyond NUM_CHAN. A write to such an address changes nothing.
- R10: Read data is registered. It reflects the address presented before a clock edge and is updated at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Level-sensitive, active-high interrupt sources shared by all channels |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_out | output | NUM_CHAN | One registered interrupt output per channel |

## Verification
The bench builds the block with 4 channels, 6 sources and a 9-bit address. This makes all 64 source patterns small enough to sweep against four distinct enable masks, comparing every output and every channel's pending word. The 9-bit address covers eight 64-byte slots, so every byte address can be visited. Half of those slots lie beyond the last channel, which exercises out-of-range channel decode along with unaligned offsets in the real slots.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Each channel owns one 64-byte slot of the register space.
    localparam int unsigned SLOT_LG = 6;

    // Offsets of the two words inside a slot.
    localparam logic [SLOT_LG-1:0] OFS_ENABLE  = 6'h10;
    localparam logic [SLOT_LG-1:0] OFS_PENDING = 6'h20;

    typedef enum logic [1:0] {
        REG_NONE    = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_PENDING = 2'd2
    } reg_kind_e;

endpackage

// File: rtl/irqc_dec.sv
module irqc_dec
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_CHAN = 8,
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned CH_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   chan
);
    localparam int unsigned SLOT_W = ADDR_W - SLOT_LG;

    logic [SLOT_W-1:0]  slot;
    logic [SLOT_LG-1:0] offs;
    logic               in_range;

    always_comb begin
        slot     = addr[ADDR_W-1:SLOT_LG];
        offs     = addr[SLOT_LG-1:0];
        in_range = (32'(slot) < NUM_CHAN);
        chan     = CH_W'(slot);
        kind     = REG_NONE;
        if (in_range) begin
            if (offs == OFS_ENABLE) begin
                kind = REG_ENABLE;
            end else if (offs == OFS_PENDING) begin
                kind = REG_PENDING;
            end
        end
    end

endmodule

// File: rtl/irqc_chan.sv
module irqc_chan #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] pend,
    output logic               irq
);
    logic irq_d;
    logic irq_q;

    always_comb begin
        pend  = src & en;
        irq_d = |pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_CHAN = 8,
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_CHAN-1:0] irq_out
);
    localparam int unsigned CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

    typedef struct packed {
        logic [NUM_CHAN-1:0][NUM_SRC-1:0] en;
        logic [DATA_W-1:0]                rdata;
    } state_t;

    state_t st_d;
    state_t st_q;

    reg_kind_e                        kind;
    logic [CH_W-1:0]                  chan;
    logic [NUM_CHAN-1:0][NUM_SRC-1:0] pend_w;

    irqc_dec #(
        .NUM_CHAN (NUM_CHAN),
        .ADDR_W   (ADDR_W),
        .CH_W     (CH_W)
    ) u_dec (
        .addr (reg_addr),
        .kind (kind),
        .chan (chan)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        irqc_chan #(
            .NUM_SRC (NUM_SRC)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src_lvl),
            .en    (st_q.en[c]),
            .pend  (pend_w[c]),
            .irq   (irq_out[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_we && (kind == REG_ENABLE)) begin
            st_d.en[chan] = reg_wdata[NUM_SRC-1:0];
        end
        case (kind)
            REG_ENABLE:  st_d.rdata = DATA_W'(st_q.en[chan]);
            REG_PENDING: st_d.rdata = DATA_W'(pend_w[chan]);
            default:     st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_CHAN = 8,
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  src_lvl,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_we,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [NUM_CHAN-1:0] irq_out
);
    // Independent view of the address map: channel slot and the offset in it.
    logic addr_mapped;
    logic addr_pend;
    always_comb begin
        addr_mapped = ((32'(reg_addr) >> 6) < NUM_CHAN) &&
                      ((reg_addr[5:0] == 6'd16) || (reg_addr[5:0] == 6'd32));
        addr_pend   = ((32'(reg_addr) >> 6) < NUM_CHAN) && (reg_addr[5:0] == 6'd32);
    end

    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_out == '0 && reg_rdata == '0));

    assert_no_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl == '0) |=> (irq_out == '0));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped |=> (reg_rdata == '0));

    assert_pend_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_pend |=> ((reg_rdata & ~DATA_W'($past(src_lvl))) == '0));

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(c * 64 + 16);

        assert_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] |-> $past(|src_lvl));

        assert_zero_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == EN_ADDR && reg_wdata[NUM_SRC-1:0] == '0)
            |=> ##1 !irq_out[c]);
    end

endmodule

bind irq_concentrator irqc_checker #(
    .NUM_CHAN (NUM_CHAN),
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_concentrator.sv
module sim_irq_concentrator;
    localparam int NC = 4;
    localparam int NS = 6;
    localparam int DW = 32;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_lvl = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NC-1:0] irq_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [NS-1:0] en_m [NC];

    always #2 clk = ~clk;

    irq_concentrator #(
        .NUM_CHAN (NC),
        .NUM_SRC  (NS),
        .DATA_W   (DW),
        .ADDR_W   (AW)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl   (src_lvl),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    function automatic int en_a(input int c);
        return c * 64 + 16;
    endfunction

    function automatic int pd_a(input int c);
        return c * 64 + 32;
    endfunction

    function automatic logic [NC-1:0] exp_irq(input logic [NS-1:0] s);
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = |(s & en_m[c]);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        @(negedge clk);
        reg_addr = AW'(a);
        reg_we   = 1'b0;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic set_src(input logic [NS-1:0] s);
        @(negedge clk);
        src_lvl = s;
        @(negedge clk);
    endtask

    task automatic check_enables(input string req);
        logic [DW-1:0] v;
        for (int c = 0; c < NC; c++) begin
            rd(en_a(c), v);
            chk(v == DW'(en_m[c]), req, v, DW'(en_m[c]));
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] prev;
        for (int c = 0; c < NC; c++) en_m[c] = '0;
        repeat (3) @(negedge clk);
        // R7: outputs quiet while and after reset
        chk(irq_out == '0, "R7 irq in reset", DW'(irq_out), 0);
        chk(reg_rdata == '0, "R7 rdata in reset", reg_rdata, 0);
        rst_n = 1'b1;
        src_lvl = '1;
        @(negedge clk);
        @(negedge clk);
        chk(irq_out == '0, "R7 no enables after reset", DW'(irq_out), 0);
        check_enables("R7 enable reset value");

        // R3: writes with junk above NUM_SRC, readback of low bits only
        en_m[0] = 6'h3F; en_m[1] = 6'h15; en_m[2] = 6'h2A; en_m[3] = 6'h21;
        for (int c = 0; c < NC; c++) wr(en_a(c), 32'hABCD_EF00 | DW'(en_m[c]) | 32'hC0);
        check_enables("R3 enable readback");

        // R1 R2 R4: every source pattern against every channel
        for (int s = 0; s < 64; s++) begin
            set_src(NS'(s));
            chk(irq_out == exp_irq(NS'(s)), "R1 R2 irq per pattern",
                DW'(irq_out), DW'(exp_irq(NS'(s))));
            for (int c = 0; c < NC; c++) begin
                rd(pd_a(c), v);
                chk(v == DW'(NS'(s) & en_m[c]), "R4 pending word", v,
                    DW'(NS'(s) & en_m[c]));
            end
        end

        // R4: no latching once the source drops
        set_src(6'h01);
        set_src(6'h00);
        for (int c = 0; c < NC; c++) begin
            rd(pd_a(c), v);
            chk(v == 0, "R4 pending follows live level", v, 0);
        end
        chk(irq_out == '0, "R1 deassert when idle", DW'(irq_out), 0);

        // R5: clear bit 0 on channel 0 only; channel 3 still sees source 0
        en_m[0] = 6'h3E;
        wr(en_a(0), 32'h3E);
        set_src(6'h01);
        chk(irq_out[0] == 1'b0, "R5 masked on channel 0", DW'(irq_out[0]), 0);
        chk(irq_out[3] == 1'b1, "R5 still live on channel 3", DW'(irq_out[3]), 1);
        check_enables("R5 other channels untouched");

        // R8: pending words ignore writes
        set_src(6'h00);
        for (int c = 0; c < NC; c++) wr(pd_a(c), 32'hFFFF_FFFF);
        check_enables("R8 pending write ignored");
        chk(irq_out == '0, "R8 no output from pending write", DW'(irq_out), 0);

        // R9: every byte address; unmapped reads zero and writes do nothing
        for (int a = 0; a < (1 << AW); a++) begin
            bit mapped;
            mapped = ((a >> 6) < NC) && (((a & 63) == 16) || ((a & 63) == 32));
            if (!mapped) begin
                wr(a, 32'hFFFF_FFFF);
                rd(a, v);
                chk(v == 0, "R9 unmapped read", v, 0);
            end
        end
        check_enables("R9 unmapped write no effect");
        chk(irq_out == '0, "R9 no output from unmapped write", DW'(irq_out), 0);

        // R10: read data changes only at the clock edge
        rd(en_a(1), prev);
        @(negedge clk);
        reg_addr = AW'(en_a(2));
        #1;
        chk(reg_rdata == prev, "R10 holds before edge", reg_rdata, prev);
        @(posedge clk);
        #1;
        chk(reg_rdata == DW'(en_m[2]), "R10 updates at edge", reg_rdata, DW'(en_m[2]));

        // R6: zero write to channel 1 with all sources high
        set_src(6'h3F);
        chk(irq_out[1] == 1'b1, "R6 precondition", DW'(irq_out[1]), 1);
        @(negedge clk);
        reg_addr  = AW'(en_a(1));
        reg_wdata = '0;
        reg_we    = 1'b1;
        @(posedge clk);
        #1;
        chk(irq_out[1] == 1'b1, "R6 one edge after write", DW'(irq_out[1]), 1);
        @(negedge clk);
        reg_we = 1'b0;
        @(posedge clk);
        #1;
        chk(irq_out[1] == 1'b0, "R6 two edges after write", DW'(irq_out[1]), 0);
        en_m[1] = '0;
        @(negedge clk);
        chk(irq_out == exp_irq(6'h3F), "R6 other channels live", DW'(irq_out),
            DW'(exp_irq(6'h3F)));
        rd(pd_a(1), v);
        chk(v == 0, "R6 pending empty", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule